// File: doc/BRIEF.md
# Dual Store Queue with Burst Flush

This block holds two write-combining buffers. Each buffer is 32 bytes wide and is organised as eight 32-bit longword slots. A CPU-side write port fills slots one longword at a time. Address bit 5 picks the buffer and bits [4:2] pick the slot. A separate readback port returns any slot through a fixed 64-byte decoded window. A flush command streams one whole buffer to external memory as an eight-beat burst on a valid/ready handshake. The burst always starts on a 32-byte boundary.

Every access is screened by the same rule set, in a fixed priority. An address error comes first. It covers a misaligned address, a wrong readback size or window, and a user-mode access while the privilege-restrict input is set. A translation miss comes next, then a protection fault. The miss and protection flags come from outside the block. A faulting write leaves the buffer untouched. A flush that faults at the command issues no beat. A flush that faults mid-burst stops at once and reports an abort.

Top module: `dual_store_queue`

## Requirements
- R1: After reset every slot reads as zero. An accepted write stores `wr_data_i` into buffer `wr_addr_i[5]`, slot `wr_addr_i[4:2]`, and pulses `wr_ack_o` in the following cycle with `wr_err_o` = 0.
- R2: A readback with `rd_size_i` = 2'b10 (longword) at `RD_BASE + buffer*0x20 + slot*4` returns the slot on `rd_data_o`, with `rd_ok_o` high, one cycle later.
- R3: A readback with a size other than 2'b10, with address bits [1:0] nonzero, or with an address outside the 64-byte window pulses `rd_err_o` and not `rd_ok_o`, and leaves `rd_data_o` unchanged.
- R4: A write with address bits [1:0] nonzero reports `wr_err_o` = 1 (address error), gets no ack and leaves the buffer unchanged.
- R5: When `priv_only_i` = 1, a user-mode write, readback or flush reports an address error (code 1) even with no translation fault. When `priv_only_i` = 0, user mode is allowed.
- R6: Write error codes are 1 address, 2 miss, 3 protection, with address over miss over protection. A faulting write leaves the buffer unchanged.
- R7: An accepted flush issues eight beats, slots 0 to 7 in order. The beat address is `{flush_addr_i[31:5], slot, 2'b00}` and the beat data is that slot. `mem_valid_o` and the beat are held while `mem_ready_i` is low. `flush_done_o` pulses in the cycle after the last handshake.
- R8: `flush_busy_o` is high from the cycle after an accepted flush until it ends. A write to the buffer being flushed is dropped, with no ack and no error. A write to the other buffer is accepted.
- R9: Fault flags at the flush command give a `flush_abort_o` pulse with the code on `flush_err_o` (1, 2 or 3) and no beat. A miss or protection flag raised during the burst blocks that cycle's beat, gives an abort pulse the next cycle, and no further beat is issued.
- R10: A flush command received while a flush is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_only_i | input | 1 | 1: only privileged accesses allowed |
| wr_valid_i | input | 1 | Write request |
| wr_addr_i | input | AW | Write address (bit 5 buffer, [4:2] slot) |
| wr_data_i | input | DW | Write longword |
| wr_user_i | input | 1 | Write made in user mode |
| wr_miss_i | input | 1 | Write translation miss |
| wr_prot_i | input | 1 | Write protection fault |
| wr_ack_o | output | 1 | Write stored (one cycle after request) |
| wr_err_o | output | 2 | Write error code |
| rd_valid_i | input | 1 | Readback request |
| rd_addr_i | input | AW | Readback address |
| rd_size_i | input | 2 | Access size, 2'b10 = longword |
| rd_user_i | input | 1 | Readback made in user mode |
| rd_ok_o | output | 1 | Readback data valid |
| rd_err_o | output | 1 | Readback address error |
| rd_data_o | output | DW | Readback data |
| flush_valid_i | input | 1 | Flush command |
| flush_addr_i | input | AW | Flush target (bit 5 also selects buffer) |
| flush_user_i | input | 1 | Flush made in user mode |
| flush_miss_i | input | 1 | Read-type miss, at command or during burst |
| flush_prot_i | input | 1 | Read-type protection fault, at command or during burst |
| flush_busy_o | output | 1 | Burst in progress |
| flush_done_o | output | 1 | Burst completed |
| flush_abort_o | output | 1 | Burst aborted or refused |
| flush_err_o | output | 2 | Abort cause code |
| mem_valid_o | output | 1 | Beat valid |
| mem_ready_i | input | 1 | Beat accepted |
| mem_addr_o | output | AW | Beat address |
| mem_data_o | output | DW | Beat data |

## Verification
The bench uses the default build: two buffers of eight 32-bit slots and a 64-byte readback window. At that size every one of the 16 slots can be written and read back. All 32 combinations of misalignment, user mode, restrict bit, miss and protection flags can be applied to writes. The expected codes and the shadow contents are computed arithmetically. Flushes of both buffers run with a free and a one-in-three stalled ready line. They also run with busy-buffer writes, a repeated command and a fault after the third beat, so the beat order, holding, rejection and abort rules are all covered.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_ADDR = 2'd1,
    ERR_MISS = 2'd2,
    ERR_PROT = 2'd3
  } sq_err_e;

  localparam logic [1:0] SZ_LONG = 2'b10;
endpackage

// File: rtl/sq_access_chk.sv
module sq_access_chk
  import sq_pkg::*;
(
  input  logic       align_ok_i,
  input  logic       user_i,
  input  logic       priv_only_i,
  input  logic       miss_i,
  input  logic       prot_i,
  output logic [1:0] err_o
);
  sq_err_e err;

  // address error wins over translation results
  always_comb begin
    if (!align_ok_i || (user_i && priv_only_i)) err = ERR_ADDR;
    else if (miss_i)                             err = ERR_MISS;
    else if (prot_i)                             err = ERR_PROT;
    else                                         err = ERR_NONE;
  end

  assign err_o = err;
endmodule

// File: rtl/sq_store.sv
module sq_store #(
  parameter int NQ    = 2,
  parameter int SLOTS = 8,
  parameter int DW    = 32,
  parameter int QW    = 1,
  parameter int SW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [QW-1:0] wq_i,
  input  logic [SW-1:0] ws_i,
  input  logic [DW-1:0] wd_i,
  input  logic [QW-1:0] rq_i,
  input  logic [SW-1:0] rs_i,
  output logic [DW-1:0] rd_o,
  input  logic [QW-1:0] fq_i,
  input  logic [SW-1:0] fs_i,
  output logic [DW-1:0] fd_o
);
  logic [NQ*SLOTS-1:0][DW-1:0] words;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    for (genvar s = 0; s < SLOTS; s++) begin : g_s
      logic [DW-1:0] word_q;
      logic          hit;
      assign hit = we_i && (wq_i == QW'(q)) && (ws_i == SW'(s));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  word_q <= '0;
        else if (hit) word_q <= wd_i;
      end
      assign words[q*SLOTS+s] = word_q;
    end
  end

  assign rd_o = words[{rq_i, rs_i}];
  assign fd_o = words[{fq_i, fs_i}];
endmodule

// File: rtl/sq_flush_ctl.sv
module sq_flush_ctl #(
  parameter int AW = 32,
  parameter int QW = 1,
  parameter int SW = 3,
  parameter int BL = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [QW-1:0] cmd_q_i,
  input  logic [AW-BL-1:0] cmd_hi_i,
  input  logic [1:0]    cmd_err_i,
  input  logic          flt_i,
  input  logic [1:0]    flt_code_i,
  input  logic          mem_ready_i,
  output logic          busy_o,
  output logic [QW-1:0] q_o,
  output logic [SW-1:0] slot_o,
  output logic          mem_valid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          done_o,
  output logic          abort_o,
  output logic [1:0]    err_o
);
  logic             busy_q;
  logic [QW-1:0]    q_q;
  logic [AW-BL-1:0] hi_q;
  logic [SW-1:0]    beat_q;
  logic             done_q, abort_q;
  logic [1:0]       err_q;
  logic             cmd_take, last;

  assign cmd_take = cmd_valid_i && !busy_q;
  assign last     = (beat_q == SW'((1 << SW) - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      q_q     <= '0;
      hi_q    <= '0;
      beat_q  <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      err_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      err_q   <= '0;
      if (cmd_take) begin
        if (cmd_err_i != 2'd0) begin
          abort_q <= 1'b1;
          err_q   <= cmd_err_i;
        end else begin
          busy_q <= 1'b1;
          q_q    <= cmd_q_i;
          hi_q   <= cmd_hi_i;
          beat_q <= '0;
        end
      end else if (busy_q) begin
        if (flt_i) begin
          busy_q  <= 1'b0;
          abort_q <= 1'b1;
          err_q   <= flt_code_i;
        end else if (mem_ready_i) begin
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
      end
    end
  end

  // a fault in the current cycle suppresses the beat handshake
  assign mem_valid_o = busy_q && !flt_i;
  assign mem_addr_o  = {hi_q, beat_q, 2'b00};
  assign busy_o      = busy_q;
  assign q_o         = q_q;
  assign slot_o      = beat_q;
  assign done_o      = done_q;
  assign abort_o     = abort_q;
  assign err_o       = err_q;
endmodule

// File: rtl/dual_store_queue.sv
module dual_store_queue
  import sq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NQ    = 2,
  parameter int SLOTS = 8,
  parameter logic [AW-1:0] RD_BASE = 'hFFF0_0400
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          priv_only_i,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_user_i,
  input  logic          wr_miss_i,
  input  logic          wr_prot_i,
  output logic          wr_ack_o,
  output logic [1:0]    wr_err_o,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [1:0]    rd_size_i,
  input  logic          rd_user_i,
  output logic          rd_ok_o,
  output logic          rd_err_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          flush_valid_i,
  input  logic [AW-1:0] flush_addr_i,
  input  logic          flush_user_i,
  input  logic          flush_miss_i,
  input  logic          flush_prot_i,
  output logic          flush_busy_o,
  output logic          flush_done_o,
  output logic          flush_abort_o,
  output logic [1:0]    flush_err_o,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o
);
  localparam int QW      = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int SW      = $clog2(SLOTS);
  localparam int BL      = SW + 2;    // burst alignment bits
  localparam int WL      = BL + QW;   // readback window bits

  // write path
  logic [QW-1:0] wr_q;
  logic [SW-1:0] wr_s;
  logic [1:0]    wr_code;
  logic          wr_blocked, wr_en;
  logic          wr_ack_q;
  logic [1:0]    wr_err_q;

  // read path
  logic [QW-1:0] rd_q;
  logic [SW-1:0] rd_s;
  logic          rd_in_win, rd_shape_ok;
  logic [1:0]    rd_code;
  logic          rd_take;
  logic [DW-1:0] rd_word;
  logic          rd_ok_q, rd_err_q;
  logic [DW-1:0] rd_data_q;

  // flush path
  logic [QW-1:0] fl_cmd_q;
  logic [1:0]    fl_cmd_code;
  logic          fl_flt;
  logic [1:0]    fl_flt_code;
  logic          fl_busy;
  logic [QW-1:0] fl_q;
  logic [SW-1:0] fl_slot;

  assign wr_q = wr_addr_i[BL +: QW];
  assign wr_s = wr_addr_i[2 +: SW];

  sq_access_chk u_wr_chk (
    .align_ok_i  (wr_addr_i[1:0] == 2'b00),
    .user_i      (wr_user_i),
    .priv_only_i (priv_only_i),
    .miss_i      (wr_miss_i),
    .prot_i      (wr_prot_i),
    .err_o       (wr_code)
  );

  assign wr_blocked = fl_busy && (wr_q == fl_q);
  assign wr_en      = wr_valid_i && (wr_code == ERR_NONE) && !wr_blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ack_q <= 1'b0;
      wr_err_q <= '0;
    end else begin
      wr_ack_q <= wr_en;
      wr_err_q <= wr_valid_i ? wr_code : 2'd0;
    end
  end

  assign rd_q        = rd_addr_i[BL +: QW];
  assign rd_s        = rd_addr_i[2 +: SW];
  assign rd_in_win   = (rd_addr_i[AW-1:WL] == RD_BASE[AW-1:WL]);
  assign rd_shape_ok = rd_in_win && (rd_addr_i[1:0] == 2'b00) && (rd_size_i == SZ_LONG);

  sq_access_chk u_rd_chk (
    .align_ok_i  (rd_shape_ok),
    .user_i      (rd_user_i),
    .priv_only_i (priv_only_i),
    .miss_i      (1'b0),
    .prot_i      (1'b0),
    .err_o       (rd_code)
  );

  assign rd_take = rd_valid_i && (rd_code == ERR_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ok_q   <= 1'b0;
      rd_err_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_ok_q  <= rd_take;
      rd_err_q <= rd_valid_i && (rd_code != ERR_NONE);
      if (rd_take) rd_data_q <= rd_word;
    end
  end

  assign fl_cmd_q = flush_addr_i[BL +: QW];

  sq_access_chk u_fl_chk (
    .align_ok_i  (1'b1),
    .user_i      (flush_user_i),
    .priv_only_i (priv_only_i),
    .miss_i      (flush_miss_i),
    .prot_i      (flush_prot_i),
    .err_o       (fl_cmd_code)
  );

  assign fl_flt      = flush_miss_i || flush_prot_i;
  assign fl_flt_code = flush_miss_i ? ERR_MISS : ERR_PROT;

  sq_flush_ctl #(
    .AW (AW),
    .QW (QW),
    .SW (SW),
    .BL (BL)
  ) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (flush_valid_i),
    .cmd_q_i     (fl_cmd_q),
    .cmd_hi_i    (flush_addr_i[AW-1:BL]),
    .cmd_err_i   (fl_cmd_code),
    .flt_i       (fl_flt),
    .flt_code_i  (fl_flt_code),
    .mem_ready_i (mem_ready_i),
    .busy_o      (fl_busy),
    .q_o         (fl_q),
    .slot_o      (fl_slot),
    .mem_valid_o (mem_valid_o),
    .mem_addr_o  (mem_addr_o),
    .done_o      (flush_done_o),
    .abort_o     (flush_abort_o),
    .err_o       (flush_err_o)
  );

  sq_store #(
    .NQ    (NQ),
    .SLOTS (SLOTS),
    .DW    (DW),
    .QW    (QW),
    .SW    (SW)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en),
    .wq_i   (wr_q),
    .ws_i   (wr_s),
    .wd_i   (wr_data_i),
    .rq_i   (rd_q),
    .rs_i   (rd_s),
    .rd_o   (rd_word),
    .fq_i   (fl_q),
    .fs_i   (fl_slot),
    .fd_o   (mem_data_o)
  );

  assign wr_ack_o     = wr_ack_q;
  assign wr_err_o     = wr_err_q;
  assign rd_ok_o      = rd_ok_q;
  assign rd_err_o     = rd_err_q;
  assign rd_data_o    = rd_data_q;
  assign flush_busy_o = fl_busy;
endmodule

// File: rtl/sq_chk.sv
module sq_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          priv_only_i,
  input logic          wr_valid_i,
  input logic          wr_user_i,
  input logic          wr_ack_o,
  input logic [1:0]    wr_err_o,
  input logic          rd_valid_i,
  input logic [AW-1:0] rd_addr_i,
  input logic          rd_ok_o,
  input logic          rd_err_o,
  input logic          mem_valid_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_data_o,
  input logic          flush_busy_o,
  input logic          flush_done_o,
  input logic          flush_abort_o
);
  localparam int BL = SW + 2;

  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i && (mem_addr_o[BL-1:2] != '1)
    |=> mem_addr_o[BL-1:2] == SW'($past(mem_addr_o[BL-1:2]) + 1'b1)); // R7

  AST_LAST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i && (mem_addr_o[BL-1:2] == '1)
    |=> flush_done_o && !flush_busy_o); // R7

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i
    |=> $stable(mem_addr_o) && $stable(mem_data_o)); // R7

  AST_DONE_ABORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flush_done_o && flush_abort_o)); // R7

  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_abort_o |-> !flush_busy_o && !mem_valid_o); // R9

  AST_USER_WR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_user_i && priv_only_i |=> (wr_err_o == 2'd1) && !wr_ack_o); // R5

  AST_RD_MISALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i && (rd_addr_i[1:0] != 2'b00) |=> rd_err_o && !rd_ok_o); // R3

  AST_WR_ACK_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |-> wr_err_o == 2'd0); // R1
endmodule

bind dual_store_queue sq_chk #(
  .AW (AW),
  .DW (DW),
  .SW (SW)
) u_sq_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .priv_only_i   (priv_only_i),
  .wr_valid_i    (wr_valid_i),
  .wr_user_i     (wr_user_i),
  .wr_ack_o      (wr_ack_o),
  .wr_err_o      (wr_err_o),
  .rd_valid_i    (rd_valid_i),
  .rd_addr_i     (rd_addr_i),
  .rd_ok_o       (rd_ok_o),
  .rd_err_o      (rd_err_o),
  .mem_valid_o   (mem_valid_o),
  .mem_ready_i   (mem_ready_i),
  .mem_addr_o    (mem_addr_o),
  .mem_data_o    (mem_data_o),
  .flush_busy_o  (flush_busy_o),
  .flush_done_o  (flush_done_o),
  .flush_abort_o (flush_abort_o)
);

// File: tb/dual_store_queue_bench.sv
`timescale 1ns/1ps
module dual_store_queue_bench;
  localparam logic [31:0] RB = 32'hFFF0_0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_only = 1'b0;
  logic        wr_valid = 1'b0, wr_user = 1'b0, wr_miss = 1'b0, wr_prot = 1'b0;
  logic [31:0] wr_addr = '0, wr_data = '0;
  logic        rd_valid = 1'b0, rd_user = 1'b0;
  logic [31:0] rd_addr = '0;
  logic [1:0]  rd_size = 2'b10;
  logic        fl_valid = 1'b0, fl_user = 1'b0, fl_miss = 1'b0, fl_prot = 1'b0;
  logic [31:0] fl_addr = '0;
  logic        mem_ready = 1'b1;

  logic        wr_ack, rd_ok, rd_err, fl_busy, fl_done, fl_abort, mem_valid;
  logic [1:0]  wr_err, fl_err;
  logic [31:0] rd_data, mem_addr, mem_data;

  int total = 0, bad = 0;
  int nb = 0, ndone = 0, nabort = 0;
  logic [31:0] b_addr [16];
  logic [31:0] b_data [16];
  logic [31:0] model [2][8];

  always #2.5 clk = ~clk;

  dual_store_queue u_dual_store_queue (
    .clk_i(clk), .rst_ni(rst_n), .priv_only_i(priv_only),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wr_user_i(wr_user), .wr_miss_i(wr_miss), .wr_prot_i(wr_prot),
    .wr_ack_o(wr_ack), .wr_err_o(wr_err),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_size_i(rd_size), .rd_user_i(rd_user),
    .rd_ok_o(rd_ok), .rd_err_o(rd_err), .rd_data_o(rd_data),
    .flush_valid_i(fl_valid), .flush_addr_i(fl_addr), .flush_user_i(fl_user),
    .flush_miss_i(fl_miss), .flush_prot_i(fl_prot),
    .flush_busy_o(fl_busy), .flush_done_o(fl_done), .flush_abort_o(fl_abort),
    .flush_err_o(fl_err),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_valid && mem_ready && nb < 16) begin
        b_addr[nb] = mem_addr;
        b_data[nb] = mem_data;
        nb = nb + 1;
      end
      if (fl_done)  ndone  = ndone + 1;
      if (fl_abort) nabort = nabort + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] pat(input int q, input int s, input int k);
    return 32'h1357_0000 + 32'(q << 12) + 32'(s << 4) + 32'(k) * 32'h0001_0101;
  endfunction

  function automatic logic [1:0] exp_code(input logic mis, input logic u, input logic po,
                                          input logic m, input logic p);
    if (mis || (u && po)) return 2'd1;
    if (m) return 2'd2;
    if (p) return 2'd3;
    return 2'd0;
  endfunction

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic u,
                    input logic m, input logic p);
    wr_addr = a; wr_data = d; wr_user = u; wr_miss = m; wr_prot = p; wr_valid = 1'b1;
    tick();
    wr_valid = 1'b0; wr_user = 1'b0; wr_miss = 1'b0; wr_prot = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [1:0] sz, input logic u);
    rd_addr = a; rd_size = sz; rd_user = u; rd_valid = 1'b1;
    tick();
    rd_valid = 1'b0; rd_user = 1'b0; rd_size = 2'b10;
  endtask

  task automatic fl(input logic [31:0] a, input logic u, input logic m, input logic p);
    fl_addr = a; fl_user = u; fl_miss = m; fl_prot = p; fl_valid = 1'b1;
    tick();
    fl_valid = 1'b0; fl_user = 1'b0; fl_miss = 1'b0; fl_prot = 1'b0;
  endtask

  task automatic readback_all(input string req);
    for (int q = 0; q < 2; q++)
      for (int s = 0; s < 8; s++) begin
        rd(RB + 32'(q * 32 + s * 4), 2'b10, 1'b0);
        check({req, " readback ok"}, {31'd0, rd_ok}, 32'd1);
        check({req, " readback data"}, rd_data, model[q][s]);
      end
  endtask

  task automatic check_beats(input string req, input int q, input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      check({req, " beat addr"}, b_addr[i], base + 32'(i * 4));
      check({req, " beat data"}, b_data[i], model[q][i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    int d0;
    int a0;
    for (int q = 0; q < 2; q++)
      for (int s = 0; s < 8; s++) model[q][s] = '0;

    repeat (3) tick();
    check("R1 reset busy", {31'd0, fl_busy}, 32'd0);
    check("R1 reset mem_valid", {31'd0, mem_valid}, 32'd0);
    check("R1 reset ack", {31'd0, wr_ack}, 32'd0);
    rst_n = 1'b1;
    tick();
    rd(RB + 32'h24, 2'b10, 1'b0);
    check("R1 reset slot zero", rd_data, 32'd0);
    check("R2 reset read ok", {31'd0, rd_ok}, 32'd1);

    // R1: fill every slot, upper address bits ignored
    for (int q = 0; q < 2; q++)
      for (int s = 0; s < 8; s++) begin
        wr(32'hE000_0000 + 32'(q * 32 + s * 4), pat(q, s, 1), 1'(s & 1), 1'b0, 1'b0);
        check("R1 write ack", {31'd0, wr_ack}, 32'd1);
        check("R1 write err", {30'd0, wr_err}, 32'd0);
        model[q][s] = pat(q, s, 1);
      end
    readback_all("R2");

    // R3: bad size, misalignment, outside window
    rd(RB + 32'h08, 2'b10, 1'b0);
    keep = rd_data;
    for (int sz = 0; sz < 4; sz++) begin
      if (sz == 2) continue;
      rd(RB + 32'h0C, 2'(sz), 1'b0);
      check("R3 size err", {31'd0, rd_err}, 32'd1);
      check("R3 size no ok", {31'd0, rd_ok}, 32'd0);
      check("R3 size data held", rd_data, keep);
    end
    for (int o = 1; o < 4; o++) begin
      rd(RB + 32'h10 + 32'(o), 2'b10, 1'b0);
      check("R3 misalign err", {31'd0, rd_err}, 32'd1);
      check("R3 misalign data held", rd_data, keep);
    end
    rd(RB + 32'h40, 2'b10, 1'b0);
    check("R3 above window err", {31'd0, rd_err}, 32'd1);
    rd(RB - 32'h4, 2'b10, 1'b0);
    check("R3 below window err", {31'd0, rd_err}, 32'd1);
    check("R3 window data held", rd_data, keep);

    // R4 R5 R6: full sweep of write fault inputs
    for (int k = 0; k < 32; k++) begin
      logic po, u, m, p, mis;
      logic [1:0] ec;
      int q, s;
      po = k[0]; u = k[1]; m = k[2]; p = k[3]; mis = k[4];
      q = (k >> 1) & 1; s = (k >> 2) & 7;
      ec = exp_code(mis, u, po, m, p);
      priv_only = po;
      wr(32'(q * 32 + s * 4) | {31'd0, mis}, pat(q, s, 2 + k), u, m, p);
      if (mis)          check("R4 misalign write code", {30'd0, wr_err}, {30'd0, ec});
      else if (u && po) check("R5 user write code", {30'd0, wr_err}, {30'd0, ec});
      else              check("R6 fault write code", {30'd0, wr_err}, {30'd0, ec});
      check("R6 ack only when clean", {31'd0, wr_ack}, {31'd0, ec == 2'd0});
      if (ec == 2'd0) model[q][s] = pat(q, s, 2 + k);
    end
    priv_only = 1'b0;
    readback_all("R6");

    // R5: readback and flush in user mode
    priv_only = 1'b1;
    rd(RB + 32'h04, 2'b10, 1'b1);
    check("R5 user read blocked", {31'd0, rd_err}, 32'd1);
    rd(RB + 32'h04, 2'b10, 1'b0);
    check("R5 priv read ok", rd_data, model[0][1]);
    nb = 0;
    a0 = nabort;
    fl(32'h4000_0C00, 1'b1, 1'b0, 1'b0);
    check("R5 user flush code", {30'd0, fl_err}, 32'd1);
    check("R5 user flush abort", {31'd0, fl_abort}, 32'd1);
    check("R5 user flush no busy", {31'd0, fl_busy}, 32'd0);
    priv_only = 1'b0;
    rd(RB + 32'h04, 2'b10, 1'b1);
    check("R5 user read allowed", {31'd0, rd_ok}, 32'd1);

    // R9: fault flags at the command
    fl(32'h4000_0C00, 1'b0, 1'b0, 1'b1);
    check("R9 cmd prot code", {30'd0, fl_err}, 32'd3);
    fl(32'h4000_0C00, 1'b0, 1'b1, 1'b1);
    check("R9 cmd miss code", {30'd0, fl_err}, 32'd2);
    repeat (3) tick();
    check("R9 cmd fault no beats", 32'(nb), 32'd0);
    check("R9 cmd fault aborts", 32'(nabort - a0), 32'd3);

    // R7: free-running flush of buffer 0, low target bits forced to zero
    nb = 0; d0 = ndone;
    fl(32'h4000_0C13, 1'b1, 1'b0, 1'b0);
    check("R8 busy after command", {31'd0, fl_busy}, 32'd1);
    for (int i = 0; i < 40 && ndone == d0; i++) tick();
    check("R7 beat count q0", 32'(nb), 32'd8);
    check("R7 done q0", 32'(ndone - d0), 32'd1);
    check("R7 idle after q0", {31'd0, fl_busy}, 32'd0);
    check_beats("R7 q0", 0, 32'h4000_0C00, 8);

    // R7 R8 R10: stalled flush of buffer 1 with traffic
    nb = 0; d0 = ndone; a0 = nabort;
    mem_ready = 1'b0;
    fl(32'h4000_0C3F, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < 80 && ndone == d0; c++) begin
      mem_ready = (c % 3 == 2);
      if (c == 1) begin
        wr_addr = 32'h28; wr_data = 32'hDEAD_BEEF; wr_valid = 1'b1;
      end
      if (c == 3) begin
        wr_addr = 32'h14; wr_data = 32'h0BAD_F00D; wr_valid = 1'b1;
      end
      if (c == 5) begin
        fl_addr = 32'h4000_0C00; fl_valid = 1'b1;
      end
      tick();
      wr_valid = 1'b0; fl_valid = 1'b0;
      if (c == 1) begin
        check("R8 busy queue write no ack", {31'd0, wr_ack}, 32'd0);
        check("R8 busy queue write no err", {30'd0, wr_err}, 32'd0);
      end
      if (c == 3) begin
        check("R8 other queue write ack", {31'd0, wr_ack}, 32'd1);
        model[0][5] = 32'h0BAD_F00D;
      end
      if (c == 5) check("R10 still busy", {31'd0, fl_busy}, 32'd1);
    end
    mem_ready = 1'b1;
    repeat (4) tick();
    check("R7 stalled beat count", 32'(nb), 32'd8);
    check("R10 single done", 32'(ndone - d0), 32'd1);
    check("R10 no abort", 32'(nabort - a0), 32'd0);
    check_beats("R7 q1", 1, 32'h4000_0C20, 8);
    rd(RB + 32'h28, 2'b10, 1'b0);
    check("R8 dropped write left slot", rd_data, model[1][2]);
    rd(RB + 32'h14, 2'b10, 1'b0);
    check("R8 other queue stored", rd_data, 32'h0BAD_F00D);

    // R9: fault after the third beat
    nb = 0; d0 = ndone; a0 = nabort;
    fl(32'h1234_5678, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 20 && nb < 3; i++) tick();
    fl_miss = 1'b1;
    tick();
    fl_miss = 1'b0;
    check("R9 mid abort pulse", {31'd0, fl_abort}, 32'd1);
    check("R9 mid abort code", {30'd0, fl_err}, 32'd2);
    check("R9 mid abort idle", {31'd0, fl_busy}, 32'd0);
    repeat (10) tick();
    check("R9 beats stop at three", 32'(nb), 32'd3);
    check("R9 no done", 32'(ndone - d0), 32'd0);
    check_beats("R9 partial", 1, 32'h1234_5660, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule